// File: doc/BRIEF.md
# Parallel Port FIFO Service Controller

This block is the host-facing half of a byte-wide extended-capability parallel port: a small byte FIFO, one extended control register, and the service logic that tells the host when the FIFO needs attention. The host reaches it over a plain register bus with three locations: the FIFO data port, the control register and a sticky error-flag register. A peripheral-side push/pop port stands in for the cable side. A direction input, which is bit 5 of the port's device control register, picks the data path. In the forward direction the host fills the FIFO and the peripheral drains it. In the reverse direction the peripheral fills it and the host drains it.

The control register has three parts. The upper bits hold a mode code, a DMA enable and an error-interrupt mask. Two read-only bits show FIFO empty and full. The service bit (bit 2) is armed when software writes it as 0. Hardware then latches it to 1 and pulses the service interrupt on the first qualifying event. Without DMA that event is a FIFO threshold whose sense depends on the direction. With DMA it is the terminal-count input. While the service bit is 1, the service interrupt and DMA requests stay quiet. A separate error interrupt follows the active-low peripheral error input unless it is masked.

Top module: `pport_fifo_svc`

## Requirements
- R1: After reset the control register reads 0x05: mode 000, DMA off, error mask off, service bit 1 and FIFO empty. The flag register reads 0x00, and svc_irq and err_irq are 0.
- R2: Control register bit 0 reads 1 exactly when the FIFO holds no bytes. Bit 1 reads 1 exactly when it holds DEPTH bytes.
- R3: The FIFO is first-in first-out. With dir_rev=0, a host write to address 0 pushes and periph_pop pops. With dir_rev=1, periph_push pushes and a host read of address 0 pops. Push requests from the other side are ignored.
- R4: A push into a full FIFO or a pop from an empty one is ignored. It sets flag-register bit 0 (overflow) or bit 1 (underflow) respectively. A host read of the flag register (address 2) returns the flags and clears them.
- R5: A host write to the control register (address 1) with any of bits 2:0 nonzero is rejected. All control fields stay unchanged and flag-register bit 2 is set.
- R6: An accepted control write stores bits 7:5 as the mode, bit 4 as the error mask and bit 3 as the DMA enable, and clears the service bit. The FIFO is flushed to empty only when the written mode differs from the current one.
- R7: With DMA off, dir_rev=0 and the service bit at 0, the block sets the service bit once the FIFO has at least THRESH free slots. svc_irq then pulses for one cycle in the clock after that condition is seen.
- R8: With DMA off, dir_rev=1 and the service bit at 0, the block sets the service bit and pulses svc_irq once at least THRESH bytes are waiting.
- R9: With DMA on, only dma_tc sets the service bit and pulses svc_irq. The FIFO thresholds have no effect.
- R10: svc_irq fires once per arming. The service bit stays 1 until software writes the register again. If the condition holds when the register is written, the bit reads 0 for one cycle and sets again on the next clock.
- R11: dma_req is 1 only while DMA is on and the service bit is 0. It also needs the FIFO not full in the forward direction, or not empty in the reverse direction.
- R12: err_irq follows, one clock later, the condition that nerr_n is 0 and the error mask (control bit 4) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 flags |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (pops data, clears flags) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for the selected register |
| dir_rev | input | 1 | Transfer direction, 1 = reverse (peripheral to host) |
| periph_push | input | 1 | Peripheral push strobe (reverse) |
| periph_wdata | input | 8 | Peripheral push data |
| periph_pop | input | 1 | Peripheral pop strobe (forward) |
| periph_rdata | output | 8 | FIFO head byte for the peripheral |
| dma_tc | input | 1 | DMA terminal-count pulse |
| dma_req | output | 1 | DMA service request |
| nerr_n | input | 1 | Peripheral error, active low |
| svc_irq | output | 1 | One-cycle service interrupt pulse |
| err_irq | output | 1 | Masked error interrupt |

## Verification
The bench builds the block with its defaults: DEPTH of 16, an 8-bit data width and a THRESH of 8. At these values, filling the FIFO to full and draining it to empty takes only sixteen transfers, so both status boundaries and both overflow and underflow are reached early. The crossing of the 8-slot threshold can be placed on an exact transfer in each direction. Every byte is compared against a queue model kept in the bench.

// File: rtl/pps_pkg.sv
// Shared definitions for the parallel port FIFO service controller.
// Assumes a two-bit host register select.
package pps_pkg;

    // Host register selects
    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_FLAG = 2'd2;

    // Mode codes held in control bits 7:5
    typedef enum logic [2:0] {
        MODE_PIO_STD  = 3'b000,
        MODE_PIO_NIB  = 3'b001,
        MODE_DMA_STD  = 3'b010,
        MODE_DMA_EXT  = 3'b011,
        MODE_PIO_EPAR = 3'b100,
        MODE_RSVD     = 3'b101,
        MODE_TEST     = 3'b110,
        MODE_CONFIG   = 3'b111
    } pps_mode_e;

endpackage

// File: rtl/pps_fifo.sv
// Byte FIFO with occupancy count, a synchronous flush, and pulses that report
// each dropped push (when full) and dropped pop (when empty).
// Assumes DEPTH is a power of two so the pointers wrap naturally.
module pps_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full,
    output logic             push_drop,
    output logic             pop_drop
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    // Status and accept decisions from the present occupancy
    always_comb begin
        empty     = (count == '0);
        full      = (count == CW'(DEPTH));
        push_ok   = push && !full && !flush;
        pop_ok    = pop && !empty && !flush;
        push_drop = push && full && !flush;
        pop_drop  = pop && empty && !flush;
        rdata     = mem[rd_ptr];
    end

    // Storage write, no reset needed
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                count <= count + 1'b1;
            end else if (pop_ok && !push_ok) begin
                count <= count - 1'b1;
            end
        end
    end

    AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> $stable(count)); // R4

    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (count == '0)); // R4

endmodule

// File: rtl/pps_ctrl.sv
// Writable fields of the control register, the rule that rejects writes,
// the mode-change flush, and the sticky error flags that clear on read.
// Assumes at most one control write per cycle.
module pps_ctrl
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    input  logic       rd_flag,
    input  logic       push_drop,
    input  logic       pop_drop,
    output pps_mode_e  mode,
    output logic       err_mask,
    output logic       dma_en,
    output logic       arm,
    output logic       flush,
    output logic [2:0] flags
);

    logic accept;
    logic reject;
    logic ovf_q, udf_q, rej_q;

    // Accept only writes whose read-only bits are zero
    always_comb begin
        accept = wr_ctrl && (wdata[2:0] == 3'b000);
        reject = wr_ctrl && (wdata[2:0] != 3'b000);
        arm    = accept;
        flush  = accept && (pps_mode_e'(wdata[7:5]) != mode);
        flags  = {rej_q, udf_q, ovf_q};
    end

    // Writable fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_PIO_STD;
            err_mask <= 1'b0;
            dma_en   <= 1'b0;
        end else if (accept) begin
            mode     <= pps_mode_e'(wdata[7:5]);
            err_mask <= wdata[4];
            dma_en   <= wdata[3];
        end
    end

    // Sticky flags: a new event wins over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            ovf_q <= push_drop || (ovf_q && !rd_flag);
            udf_q <= pop_drop  || (udf_q && !rd_flag);
            rej_q <= reject    || (rej_q && !rd_flag);
        end
    end

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> ($stable(mode) && $stable(err_mask) && $stable(dma_en))); // R5

endmodule

// File: rtl/pps_svc.sv
// Service bit and interrupt, DMA request and masked error interrupt.
// Assumes count is the registered FIFO occupancy and dma_tc is one cycle wide.
module pps_svc #(
    parameter int DEPTH  = 16,
    parameter int THRESH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          dma_en,
    input  logic          dir_rev,
    input  logic [CW-1:0] count,
    input  logic          empty,
    input  logic          full,
    input  logic          dma_tc,
    input  logic          err_mask,
    input  logic          nerr_n,
    output logic          svc_bit,
    output logic          svc_irq,
    output logic          dma_req,
    output logic          err_irq
);

    logic fwd_evt;
    logic rev_evt;
    logic evt;

    // Qualifying service event for the present mode and direction
    always_comb begin
        fwd_evt = (CW'(DEPTH) - count) >= CW'(THRESH);
        rev_evt = count >= CW'(THRESH);
        evt     = dma_en ? dma_tc : (dir_rev ? rev_evt : fwd_evt);
        dma_req = dma_en && !svc_bit && (dir_rev ? !empty : !full);
    end

    // Arm on write, latch and pulse on the first event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_bit <= 1'b1;
            svc_irq <= 1'b0;
        end else if (arm) begin
            svc_bit <= 1'b0;
            svc_irq <= 1'b0;
        end else if (!svc_bit && evt) begin
            svc_bit <= 1'b1;
            svc_irq <= 1'b1;
        end else begin
            svc_irq <= 1'b0;
        end
    end

    // Registered, masked error interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_irq <= 1'b0;
        end else begin
            err_irq <= !nerr_n && !err_mask;
        end
    end

    AST_SVC_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_bit && evt && !arm) |=> (svc_bit && svc_irq)); // R7

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |=> !svc_irq); // R10

    AST_IRQ_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        svc_bit |=> !svc_irq); // R10

endmodule

// File: rtl/pport_fifo_svc.sv
// Top of the parallel port FIFO service controller. Routes host and
// peripheral strobes to the FIFO by direction and assembles host read data.
// Assumes the host never writes and reads in the same cycle.
module pport_fifo_svc
    import pps_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 16,
    parameter int THRESH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             dir_rev,
    input  logic             periph_push,
    input  logic [WIDTH-1:0] periph_wdata,
    input  logic             periph_pop,
    output logic [WIDTH-1:0] periph_rdata,
    input  logic             dma_tc,
    output logic             dma_req,
    input  logic             nerr_n,
    output logic             svc_irq,
    output logic             err_irq
);

    logic             f_push, f_pop, f_flush;
    logic [WIDTH-1:0] f_wdata, f_rdata;
    logic [CW-1:0]    f_count;
    logic             f_empty, f_full, f_push_drop, f_pop_drop;
    pps_mode_e        mode;
    logic             err_mask, dma_en, arm, svc_bit;
    logic [2:0]       flags;
    logic             wr_ctrl, rd_flag, wr_data, rd_data;

    // Strobe decode and direction routing
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == SEL_CTRL);
        wr_data = bus_wr && (bus_addr == SEL_DATA);
        rd_data = bus_rd && (bus_addr == SEL_DATA);
        rd_flag = bus_rd && (bus_addr == SEL_FLAG);
        f_push  = dir_rev ? periph_push : wr_data;
        f_wdata = dir_rev ? periph_wdata : WIDTH'(bus_wdata);
        f_pop   = dir_rev ? rd_data : periph_pop;
        periph_rdata = f_rdata;
    end

    // Host read data
    always_comb begin
        case (bus_addr)
            SEL_DATA: bus_rdata = 8'(f_rdata);
            SEL_CTRL: bus_rdata = {mode, err_mask, dma_en, svc_bit, f_full, f_empty};
            SEL_FLAG: bus_rdata = {5'b0, flags};
            default:  bus_rdata = 8'h00;
        endcase
    end

    pps_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(f_push), .wdata(f_wdata), .pop(f_pop), .flush(f_flush),
        .rdata(f_rdata), .count(f_count), .empty(f_empty), .full(f_full),
        .push_drop(f_push_drop), .pop_drop(f_pop_drop)
    );

    pps_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_ctrl), .wdata(bus_wdata), .rd_flag(rd_flag),
        .push_drop(f_push_drop), .pop_drop(f_pop_drop),
        .mode(mode), .err_mask(err_mask), .dma_en(dma_en),
        .arm(arm), .flush(f_flush), .flags(flags)
    );

    pps_svc #(.DEPTH(DEPTH), .THRESH(THRESH)) u_svc (
        .clk(clk), .rst_n(rst_n),
        .arm(arm), .dma_en(dma_en), .dir_rev(dir_rev), .count(f_count),
        .empty(f_empty), .full(f_full), .dma_tc(dma_tc),
        .err_mask(err_mask), .nerr_n(nerr_n),
        .svc_bit(svc_bit), .svc_irq(svc_irq), .dma_req(dma_req), .err_irq(err_irq)
    );

endmodule

// File: tb/pport_fifo_svc_bench.sv
// Directed bench for pport_fifo_svc with a queue model of the FIFO.
module pport_fifo_svc_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       dir_rev = 1'b0;
    logic       periph_push = 1'b0, periph_pop = 1'b0;
    logic [7:0] periph_wdata = 8'h00;
    logic [7:0] periph_rdata;
    logic       dma_tc = 1'b0, dma_req;
    logic       nerr_n = 1'b1;
    logic       svc_irq, err_irq;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    logic [7:0] q [$];

    pport_fifo_svc u_pport_fifo_svc (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dir_rev(dir_rev), .periph_push(periph_push), .periph_wdata(periph_wdata),
        .periph_pop(periph_pop), .periph_rdata(periph_rdata), .dma_tc(dma_tc),
        .dma_req(dma_req), .nerr_n(nerr_n), .svc_irq(svc_irq), .err_irq(err_irq)
    );

    always #4 clk = ~clk;

    // Count service pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n && svc_irq) irq_cnt++;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic p_push(input logic [7:0] d);
        @(negedge clk);
        periph_wdata = d; periph_push = 1'b1;
        @(posedge clk); #1;
        periph_push = 1'b0;
    endtask

    task automatic p_pop(output logic [7:0] d);
        @(negedge clk);
        d = periph_rdata; periph_pop = 1'b1;
        @(posedge clk); #1;
        periph_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(2'd1, v); chk("R1 ctrl after reset", v, 8'h05);
        bus_read(2'd2, v); chk("R1 flags after reset", v, 8'h00);
        chk("R1 svc_irq after reset", {7'b0, svc_irq}, 8'h00);
        chk("R1 err_irq after reset", {7'b0, err_irq}, 8'h00);
    endtask

    task automatic t_forward();
        logic [7:0] v;
        for (int i = 0; i < 16; i++) begin
            bus_write(2'd0, 8'hA0 + 8'(i)); q.push_back(8'hA0 + 8'(i));
        end
        bus_read(2'd1, v); chk("R2 full status", v, 8'h06);
        bus_write(2'd0, 8'h55);
        bus_read(2'd2, v); chk("R4 overflow flag", v, 8'h01);
        bus_read(2'd2, v); chk("R4 flag cleared on read", v, 8'h00);
        chk("R7 no pulse while masked", 8'(irq_cnt), 8'd0);
        bus_write(2'd1, 8'h00);
        idle(2);
        bus_read(2'd1, v); chk("R6 armed, same mode keeps FIFO", v, 8'h02);
        for (int i = 0; i < 7; i++) begin
            p_pop(v); chk("R3 forward order", v, q.pop_front());
        end
        idle(2);
        chk("R7 no pulse at 7 free", 8'(irq_cnt), 8'd0);
        p_pop(v); chk("R3 forward order", v, q.pop_front());
        idle(2);
        chk("R7 pulse at 8 free", 8'(irq_cnt), 8'd1);
        bus_read(2'd1, v); chk("R7 service bit set", v, 8'h04);
        while (q.size() > 0) begin
            p_pop(v); chk("R3 forward order", v, q.pop_front());
        end
        bus_read(2'd1, v); chk("R2 empty status", v, 8'h05);
        chk("R10 single pulse per arming", 8'(irq_cnt), 8'd1);
        p_pop(v);
        bus_read(2'd2, v); chk("R4 underflow flag", v, 8'h02);
    endtask

    task automatic t_rearm();
        logic [7:0] v;
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, v); chk("R10 bit low for one cycle", v, 8'h01);
        bus_read(2'd1, v); chk("R10 bit set again", v, 8'h05);
        chk("R10 re-arm pulse", 8'(irq_cnt), 8'd2);
    endtask

    task automatic t_reverse();
        logic [7:0] v;
        @(negedge clk); dir_rev = 1'b1;
        bus_write(2'd1, 8'h20);
        for (int i = 0; i < 7; i++) begin
            p_push(8'h30 + 8'(i)); q.push_back(8'h30 + 8'(i));
        end
        bus_write(2'd0, 8'h99);
        idle(2);
        chk("R8 no pulse at 7 waiting", 8'(irq_cnt), 8'd2);
        p_push(8'h37); q.push_back(8'h37);
        idle(2);
        chk("R8 pulse at 8 waiting", 8'(irq_cnt), 8'd3);
        bus_read(2'd1, v); chk("R8 service bit set", v, 8'h24);
        while (q.size() > 0) begin
            bus_read(2'd0, v); chk("R3 reverse order, host write ignored", v, q.pop_front());
        end
        bus_read(2'd1, v); chk("R3 reverse drained", v, 8'h25);
    endtask

    task automatic t_reject();
        logic [7:0] v;
        bus_write(2'd1, 8'hE3);
        bus_read(2'd1, v); chk("R5 rejected write keeps register", v, 8'h25);
        bus_read(2'd2, v); chk("R5 reject flag", v, 8'h04);
    endtask

    task automatic t_flush();
        logic [7:0] v;
        for (int i = 0; i < 3; i++) p_push(8'h70 + 8'(i));
        bus_write(2'd1, 8'h40);
        bus_read(2'd1, v); chk("R6 mode change flushes", v, 8'h41);
        for (int i = 0; i < 3; i++) begin
            p_push(8'h80 + 8'(i)); q.push_back(8'h80 + 8'(i));
        end
        bus_write(2'd1, 8'h40);
        bus_read(2'd1, v); chk("R6 same mode keeps data", v, 8'h40);
        while (q.size() > 0) begin
            bus_read(2'd0, v); chk("R6 kept bytes", v, q.pop_front());
        end
    endtask

    task automatic t_dma();
        logic [7:0] v;
        int base;
        @(negedge clk); dir_rev = 1'b0;
        idle(2);
        bus_write(2'd1, 8'h08);
        idle(3);
        base = irq_cnt;
        idle(3);
        chk("R9 threshold ignored with DMA", 8'(irq_cnt - base), 8'd0);
        chk("R11 forward request", {7'b0, dma_req}, 8'h01);
        bus_read(2'd1, v); chk("R9 armed in DMA mode", v, 8'h09);
        @(negedge clk); dma_tc = 1'b1;
        @(negedge clk); dma_tc = 1'b0;
        idle(2);
        chk("R9 terminal count pulse", 8'(irq_cnt - base), 8'd1);
        chk("R11 request masked by service bit", {7'b0, dma_req}, 8'h00);
        @(negedge clk); dma_tc = 1'b1;
        @(negedge clk); dma_tc = 1'b0;
        idle(2);
        chk("R10 no second pulse", 8'(irq_cnt - base), 8'd1);
        @(negedge clk); dir_rev = 1'b1;
        bus_write(2'd1, 8'h08);
        idle(1);
        chk("R11 reverse empty no request", {7'b0, dma_req}, 8'h00);
        p_push(8'hC3);
        chk("R11 reverse data request", {7'b0, dma_req}, 8'h01);
        bus_read(2'd0, v); chk("R3 reverse byte", v, 8'hC3);
    endtask

    task automatic t_err();
        @(negedge clk); nerr_n = 1'b0;
        idle(2);
        chk("R12 error interrupt", {7'b0, err_irq}, 8'h01);
        bus_write(2'd1, 8'h18);
        idle(2);
        chk("R12 error masked", {7'b0, err_irq}, 8'h00);
        @(negedge clk); nerr_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_forward();
        t_rearm();
        t_reverse();
        t_reject();
        t_flush();
        t_dma();
        t_err();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule